// File: doc/BRIEF.md
# Flash Row Write Latch Buffer

This block collects one row of program words before that row is committed to flash. The row has 32 entries of 24 bits. A host fills it with table writes. A low-half write supplies bits 15:0 of an entry and a high-half write supplies bits 23:16. The entry is selected by the word-address bits that sit just above the byte bit of the write address. Every table write also records its full effective address, split into a lower 16-bit part and an upper 8-bit part.

Loading must follow a fixed order. It starts on a 32-word-aligned entry 0 and climbs one entry at a time. The load stays inside the row and the 128-row panel chosen by its first write. A write that breaks these rules is refused and raises a sticky error flag, so the host knows it must re-point its table pointer. When the host pulses commit, the block reports whether the row is complete and clean, together with the row-in-panel number, the panel number and the whole 768-bit row image. The flash array interface consumes these. Commit then re-arms the buffer for the next row.

Address layout: bit 0 is the byte bit, bits 5:1 are the entry index, bits 12:6 are the row within the panel, and bits 23:13 are the panel number.

Top module: `flash_row_latch`

## Requirements
- R1: After reset, row_full, err_order, err_panel and commit_valid are 0. addr_lo, addr_hi and every bit of row_data are 0.
- R2: An accepted write with wr_half=0 stores wr_data[15:0] into bits 15:0 of entry wr_addr[5:1]. An accepted write with wr_half=1 stores wr_data[7:0] into bits 23:16 of that entry, and wr_data[15:8] is ignored. wr_addr[0] has no effect on the entry chosen. Entry e sits at row_data[24*e+23:24*e].
- R3: Every write, whether accepted, refused or made in a commit cycle, loads wr_addr[15:0] into addr_lo and wr_addr[23:16] into addr_hi. The new values are visible from the next clock edge.
- R4: Entries load in ascending order. The load moves to the next entry once both halves of the current entry have been written, in either order, and a half may be rewritten before then. A write to any other entry of the row is not stored and sets err_order.
- R5: The first write of a load must target entry 0. Otherwise it is not stored, sets err_order, and the load does not begin.
- R6: A write whose panel (bits 23:13) differs from that of the first write of the load is not stored and sets err_panel. A write in the same panel but in another row (bits 12:6) is not stored and sets err_order.
- R7: row_full rises once both halves of entry 31 are written. Any later write before commit is not stored and sets err_order.
- R8: One cycle after commit, commit_valid pulses high for one cycle if and only if row_full was set and both error flags were clear. During that pulse, commit_row and commit_panel give bits 12:6 and 23:13 of the load's first write, and row_data holds the row.
- R9: Error flags stay set until commit. Commit clears row_full and both error flags and restarts the load at entry 0. A write made in the same cycle as commit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_half | input | 1 | 0 = low half (bits 15:0), 1 = high half (bits 23:16) |
| wr_addr | input | 24 | Effective byte address of the write |
| wr_data | input | 16 | Write data |
| commit | input | 1 | Commit request pulse |
| addr_lo | output | 16 | Captured address bits 15:0 of the last write |
| addr_hi | output | 8 | Captured address bits 23:16 of the last write |
| row_full | output | 1 | All 32 entries loaded |
| err_order | output | 1 | Sticky ordering or alignment error |
| err_panel | output | 1 | Sticky panel-crossing error |
| commit_valid | output | 1 | One-cycle pulse: a clean, full row is presented |
| commit_row | output | 7 | Row within panel of the committed row |
| commit_panel | output | 11 | Panel number of the committed row |
| row_data | output | 768 | Row image, entry e at bits 24*e+23:24*e |

## Verification
The assertions take for granted that wr_en, wr_half and commit are never unknown once reset has been released. They also assume that every change of the expected entry comes from an accepted write or from commit. The stimulus drives all inputs on the falling edge and holds each write for exactly one cycle with an idle cycle after it. Refused writes are injected only as single well-formed writes with a wrong entry, row or panel, so every address the design sees is fully defined.

// File: rtl/flr_pkg.sv
package flr_pkg;

  // Which half of a 24-bit entry a table write carries
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

endpackage

// File: rtl/flr_addr_split.sv
// Splits a word address (byte bit already removed) into entry, row and panel.
module flr_addr_split #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned RIP_W  = 7,
  localparam int unsigned ROW_W = ADDR_W - 1 - IDX_W
) (
  input  logic [ADDR_W-1:1] word_addr,
  output logic [IDX_W-1:0]  idx,
  output logic [ROW_W-1:0]  row_id
);

  assign idx    = word_addr[IDX_W:1];
  assign row_id = word_addr[ADDR_W-1:IDX_W+1];

endmodule

// File: rtl/flr_latch_bank.sv
// Per-entry storage with separate low and high half write enables.
module flr_latch_bank #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned LO_W    = 16,
  localparam int unsigned HI_W   = WORD_W - LO_W
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic [ENTRIES-1:0]        lo_we,
  input  logic [ENTRIES-1:0]        hi_we,
  input  logic [LO_W-1:0]           din,
  output logic [ENTRIES*WORD_W-1:0] row_data
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [WORD_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else begin
        if (lo_we[e]) ent_q[LO_W-1:0]      <= din;
        if (hi_we[e]) ent_q[WORD_W-1:LO_W] <= din[HI_W-1:0];
      end
    end
    assign row_data[e*WORD_W +: WORD_W] = ent_q;
  end

  // R2: at most one half of one entry is written per cycle
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({lo_we, hi_we}));

endmodule

// File: rtl/flr_load_ctrl.sv
// Load sequencing, alignment/order/panel checks and commit decision.
module flr_load_ctrl
  import flr_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned RIP_W   = 7,
  parameter int unsigned ROW_W   = 18,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_en,
  input  logic               wr_half,
  input  logic               commit,
  input  logic [IDX_W-1:0]   idx,
  input  logic [ROW_W-1:0]   row_id,
  output logic [ENTRIES-1:0] lo_we,
  output logic [ENTRIES-1:0] hi_we,
  output logic               full,
  output logic               err_order,
  output logic               err_panel,
  output logic               commit_valid,
  output logic [ROW_W-1:0]   base_row
);

  logic             active_q, active_d;
  logic [IDX_W-1:0] exp_q, exp_d;
  logic             lo_q, lo_d, hi_q, hi_d;
  logic             full_q, full_d;
  logic             eo_q, eo_d, ep_q, ep_d;
  logic             cv_q, cv_d;
  logic [ROW_W-1:0] base_q, base_d;
  logic             accept, lo_now, hi_now;
  half_e            half;

  assign half = half_e'(wr_half);

  always_comb begin
    active_d = active_q;
    exp_d    = exp_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    full_d   = full_q;
    eo_d     = eo_q;
    ep_d     = ep_q;
    base_d   = base_q;
    cv_d     = 1'b0;
    lo_we    = '0;
    hi_we    = '0;
    accept   = 1'b0;
    lo_now   = 1'b0;
    hi_now   = 1'b0;
    if (commit) begin
      cv_d     = full_q && !eo_q && !ep_q;
      active_d = 1'b0;
      exp_d    = '0;
      lo_d     = 1'b0;
      hi_d     = 1'b0;
      full_d   = 1'b0;
      eo_d     = 1'b0;
      ep_d     = 1'b0;
    end else if (wr_en) begin
      if (!active_q) begin
        if (idx == '0) begin
          accept   = 1'b1;
          active_d = 1'b1;
          base_d   = row_id;
        end else begin
          eo_d = 1'b1;
        end
      end else if (full_q) begin
        eo_d = 1'b1;
      end else if (row_id[ROW_W-1:RIP_W] != base_q[ROW_W-1:RIP_W]) begin
        ep_d = 1'b1;
      end else if (row_id != base_q || idx != exp_q) begin
        eo_d = 1'b1;
      end else begin
        accept = 1'b1;
      end
      if (accept) begin
        lo_we[idx] = (half == HALF_LO);
        hi_we[idx] = (half == HALF_HI);
        lo_now     = lo_q || (half == HALF_LO);
        hi_now     = hi_q || (half == HALF_HI);
        if (lo_now && hi_now) begin
          lo_d = 1'b0;
          hi_d = 1'b0;
          if (exp_q == IDX_W'(ENTRIES - 1)) full_d = 1'b1;
          else                              exp_d  = exp_q + 1'b1;
        end else begin
          lo_d = lo_now;
          hi_d = hi_now;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      exp_q    <= '0;
      lo_q     <= 1'b0;
      hi_q     <= 1'b0;
      full_q   <= 1'b0;
      eo_q     <= 1'b0;
      ep_q     <= 1'b0;
      cv_q     <= 1'b0;
      base_q   <= '0;
    end else begin
      active_q <= active_d;
      exp_q    <= exp_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      full_q   <= full_d;
      eo_q     <= eo_d;
      ep_q     <= ep_d;
      cv_q     <= cv_d;
      base_q   <= base_d;
    end
  end

  assign full         = full_q;
  assign err_order    = eo_q;
  assign err_panel    = ep_q;
  assign commit_valid = cv_q;
  assign base_row     = base_q;

  // R4: expected entry only ever steps up by one, except on commit
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (!commit && exp_d != exp_q) |-> (exp_d == IDX_W'(exp_q + 1'b1)));
  // R9: error flags are sticky until commit
  a_r9_order_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_order && !commit) |=> err_order);
  a_r9_panel_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_panel && !commit) |=> err_panel);
  // R9: commit clears the load state
  a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    commit |=> (!full && !err_order && !err_panel));
  // R7: a full row stays full until commit
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (full && !commit) |=> full);
  // R8: a presented row was full and error free
  a_r8_valid_needs_full: assert property (@(posedge clk) disable iff (!rst_ni)
    commit_valid |-> ($past(full) && !$past(err_order) && !$past(err_panel)));

endmodule

// File: rtl/flash_row_latch.sv
module flash_row_latch #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned RIP_W  = 7,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned LO_W   = 16,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned ROW_W   = ADDR_W - 1 - IDX_W,
  localparam int unsigned PANEL_W = ROW_W - RIP_W,
  localparam int unsigned UP_W    = ADDR_W - LO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_half,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LO_W-1:0]           wr_data,
  input  logic                      commit,
  output logic [LO_W-1:0]           addr_lo,
  output logic [UP_W-1:0]           addr_hi,
  output logic                      row_full,
  output logic                      err_order,
  output logic                      err_panel,
  output logic                      commit_valid,
  output logic [RIP_W-1:0]          commit_row,
  output logic [PANEL_W-1:0]        commit_panel,
  output logic [ENTRIES*WORD_W-1:0] row_data
);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // Captured effective address of the last table write
  logic [ADDR_W-1:0] cap_q, cap_d;
  always_comb begin
    cap_d = cap_q;
    if (wr_en) cap_d = wr_addr;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) cap_q <= '0;
    else        cap_q <= cap_d;
  end
  assign addr_lo = cap_q[LO_W-1:0];
  assign addr_hi = cap_q[ADDR_W-1:LO_W];

  logic [IDX_W-1:0]   idx;
  logic [ROW_W-1:0]   row_id, base_row;
  logic [ENTRIES-1:0] lo_we, hi_we;

  flr_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RIP_W(RIP_W)) u_split (
    .word_addr (wr_addr[ADDR_W-1:1]),
    .idx       (idx),
    .row_id    (row_id)
  );

  flr_load_ctrl #(.IDX_W(IDX_W), .RIP_W(RIP_W), .ROW_W(ROW_W)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_q),
    .wr_en        (wr_en),
    .wr_half      (wr_half),
    .commit       (commit),
    .idx          (idx),
    .row_id       (row_id),
    .lo_we        (lo_we),
    .hi_we        (hi_we),
    .full         (row_full),
    .err_order    (err_order),
    .err_panel    (err_panel),
    .commit_valid (commit_valid),
    .base_row     (base_row)
  );

  flr_latch_bank #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .LO_W(LO_W)) u_bank (
    .clk      (clk),
    .rst_ni   (rst_q),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .din      (wr_data),
    .row_data (row_data)
  );

  assign commit_row   = base_row[RIP_W-1:0];
  assign commit_panel = base_row[ROW_W-1:RIP_W];

  // R3: address capture follows every write
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en |=> ({addr_hi, addr_lo} == $past(wr_addr)));
  // R3: without a write, the captured address holds
  a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !wr_en |=> $stable({addr_hi, addr_lo}));

endmodule

// File: tb/test_flash_row_latch.sv
module test_flash_row_latch;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_half = 1'b0;
  logic [23:0]  wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         commit = 1'b0;
  logic [15:0]  addr_lo;
  logic [7:0]   addr_hi;
  logic         row_full, err_order, err_panel, commit_valid;
  logic [6:0]   commit_row;
  logic [10:0]  commit_panel;
  logic [767:0] row_data;

  always #2 clk = ~clk;

  flash_row_latch i_flash_row_latch (
    .clk, .rst_n, .wr_en, .wr_half, .wr_addr, .wr_data, .commit,
    .addr_lo, .addr_hi, .row_full, .err_order, .err_panel,
    .commit_valid, .commit_row, .commit_panel, .row_data
  );

  int checks = 0;
  int failures = 0;

  // Model of the requirements
  bit          m_active, m_lo, m_hi, m_full, m_eo, m_ep;
  int          m_exp;
  logic [17:0] m_base;
  logic [23:0] m_addr;
  logic [23:0] m_lat [32];

  function automatic logic [23:0] mk_addr(int panel, int rip, int idx, bit b0);
    return {panel[10:0], rip[6:0], idx[4:0], b0};
  endfunction

  function automatic logic [767:0] model_row();
    logic [767:0] r;
    for (int e = 0; e < 32; e++) r[e*24 +: 24] = m_lat[e];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_row(string req);
    checks++;
    if (row_data !== model_row()) begin
      failures++;
      $display("FAIL %s row_data actual=%0h expected=%0h", req, row_data, model_row());
    end
  endtask

  task automatic model_clear();
    m_active = 0; m_exp = 0; m_lo = 0; m_hi = 0; m_full = 0; m_eo = 0; m_ep = 0;
  endtask

  task automatic model_write(bit h, logic [23:0] a, logic [15:0] d);
    int idx;
    logic [17:0] row;
    bit acc;
    idx = int'(a[5:1]);
    row = a[23:6];
    acc = 0;
    m_addr = a;
    if (!m_active) begin
      if (idx == 0) begin acc = 1; m_active = 1; m_base = row; end
      else m_eo = 1;
    end else if (m_full) m_eo = 1;
    else if (row[17:7] != m_base[17:7]) m_ep = 1;
    else if (row != m_base || idx != m_exp) m_eo = 1;
    else acc = 1;
    if (acc) begin
      if (h) begin m_lat[idx][23:16] = d[7:0]; m_hi = 1; end
      else begin m_lat[idx][15:0] = d; m_lo = 1; end
      if (m_lo && m_hi) begin
        m_lo = 0; m_hi = 0;
        if (m_exp == 31) m_full = 1; else m_exp++;
      end
    end
  endtask

  task automatic chk_state(string req);
    chk(req, "err_order", err_order, m_eo);
    chk(req, "err_panel", err_panel, m_ep);
    chk(req, "row_full", row_full, m_full);
    chk("R3", "captured_addr", {addr_hi, addr_lo}, m_addr);
  endtask

  task automatic do_write(string req, bit h, logic [23:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_half = h; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(h, a, d);
    chk_state(req);
  endtask

  // Commit, optionally with a write in the same cycle (R9)
  task automatic do_commit(bit with_wr, bit h, logic [23:0] a, logic [15:0] d);
    bit exp_cv;
    @(negedge clk);
    commit = 1;
    if (with_wr) begin wr_en = 1; wr_half = h; wr_addr = a; wr_data = d; end
    @(negedge clk);
    commit = 0; wr_en = 0;
    exp_cv = m_full && !m_eo && !m_ep;
    chk("R8", "commit_valid", commit_valid, exp_cv);
    if (exp_cv) begin
      chk("R8", "commit_row", commit_row, m_base[6:0]);
      chk("R8", "commit_panel", commit_panel, m_base[17:7]);
    end
    chk_row("R8");
    if (with_wr) m_addr = a;
    model_clear();
    chk_state("R9");
    chk_row("R9");
    @(negedge clk);
    chk("R8", "commit_valid_pulse", commit_valid, 1'b0);
  endtask

  task automatic load_row(int p, int r, bit hi_first);
    for (int i = 0; i < 32; i++) begin
      bit f;
      f = hi_first ^ bit'(i % 2);
      do_write("R4", f, mk_addr(p, r, i, 1'b0), 16'($urandom));
      do_write("R2", !f, mk_addr(p, r, i, 1'($urandom)), 16'($urandom));
    end
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    for (int e = 0; e < 32; e++) m_lat[e] = '0;
    model_clear();
    m_base = '0;
    m_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "commit_valid", commit_valid, 1'b0);
    chk_state("R1");
    chk_row("R1");

    // R2/R4/R7/R8: clean row, low half first
    load_row(5, 3, 1'b0);
    chk("R7", "row_full", row_full, 1'b1);
    do_commit(0, 0, '0, '0);

    // R7: extra write after full is refused
    load_row(2047, 127, 1'b1);
    do_write("R7", 0, mk_addr(2047, 127, 0, 0), 16'hBEEF);
    chk_row("R7");
    do_commit(0, 0, '0, '0);

    // R5: misaligned start
    do_write("R5", 0, mk_addr(9, 1, 3, 0), 16'h1234);
    chk_row("R5");
    do_write("R5", 1, mk_addr(9, 1, 0, 0), 16'h00AB);
    do_commit(0, 0, '0, '0);

    // R4: out-of-order entry, then rewrite of a half
    do_write("R4", 0, mk_addr(12, 40, 0, 0), 16'h1111);
    do_write("R4", 0, mk_addr(12, 40, 0, 0), 16'h2222);
    do_write("R4", 1, mk_addr(12, 40, 2, 0), 16'h0033);
    chk_row("R4");
    do_commit(0, 0, '0, '0);

    // R6: panel crossing and row change inside panel
    do_write("R6", 0, mk_addr(20, 5, 0, 0), 16'hA5A5);
    do_write("R6", 1, mk_addr(21, 5, 0, 0), 16'h005A);
    do_write("R6", 1, mk_addr(20, 6, 0, 0), 16'h0077);
    chk_row("R6");
    do_commit(0, 0, '0, '0);

    // R9: write in the commit cycle is not stored
    do_write("R9", 0, mk_addr(30, 2, 0, 0), 16'hCAFE);
    do_commit(1, 1, mk_addr(30, 2, 0, 0), 16'h00EE);
    // R8: partial row gives no valid; R9: load restarts at entry 0
    do_write("R9", 1, mk_addr(31, 9, 0, 0), 16'h0042);
    do_commit(0, 0, '0, '0);

    // Random rows with injected faults
    for (int n = 0; n < 24; n++) begin
      int p, r;
      p = int'($urandom % 2048);
      r = int'($urandom % 128);
      if ($urandom % 5 == 0)
        do_write("R5", 1'($urandom), mk_addr(p, r, 1 + int'($urandom % 31), 0), 16'($urandom));
      for (int i = 0; i < 32; i++) begin
        bit f;
        f = 1'($urandom);
        for (int k = 0; k < 2; k++) begin
          if ($urandom % 24 == 0) begin
            int kind;
            kind = int'($urandom % 3);
            if (kind == 0)
              do_write("R4", 1'($urandom), mk_addr(p, r, (i + 1 + int'($urandom % 30)) % 32, 0), 16'($urandom));
            else if (kind == 1)
              do_write("R6", 1'($urandom), mk_addr((p + 1) % 2048, r, i, 0), 16'($urandom));
            else
              do_write("R6", 1'($urandom), mk_addr(p, (r + 1) % 128, i, 0), 16'($urandom));
          end
          do_write("R2", f ^ bit'(k), mk_addr(p, r, i, 1'($urandom)), 16'($urandom));
        end
      end
      if ($urandom % 4 == 0)
        do_write("R7", 1'($urandom), mk_addr(p, r, int'($urandom % 32), 0), 16'($urandom));
      do_commit(0, 0, '0, '0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule